// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls one general-purpose I/O port of up to sixteen pins. Software reaches it through a simple word-addressed register bus with an address, a write strobe, write data and combinational read data. For each pin it holds a direction mode, an output type, a pull selection, a 4-bit alternate-function number and an output latch bit. From these it derives the pad controls: the output value, the output enable, the open-drain flag, the pull-up and pull-down requests, an alternate-function enable and the function select.

The output latch can be written as a whole. It can also be changed atomically through a set/clear register, so that one write raises some pins and lowers others without a read-modify-write. Pad input levels pass through a synchroniser before software reads them.

Register word map (bus_addr): 0 mode, 1 output type, 2 pull, 3 output latch, 4 input levels, 5 set/clear, 6 function select for pins 0-7, 7 function select for pins 8-15. All other addresses are unmapped.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, and every pad sits in input mode with no output enable, no pulls, the push-pull type and function select 0.
- R2: Pin n's mode is bits 2n+1:2n of the mode register. Code 01 is output: in push-pull type pad_oe[n]=1 and pad_out[n] equals the latch bit.
- R3: Mode codes 00 (input) and 11 (reserved) give pad_oe[n]=0 and pad_alt_en[n]=0. Code 10 gives pad_alt_en[n]=1 with pad_oe[n]=0 and pad_out[n]=0.
- R4: Output-type bit n set to 1 selects open drain and appears on pad_od[n]. An open-drain output pin drives pad_out[n]=0 with pad_oe[n]=1 when its latch bit is 0, and releases the pad (pad_oe[n]=0) when the bit is 1.
- R5: Pull field bits 2n+1:2n: 01 asserts pad_pu[n], 10 asserts pad_pd[n], and 00 or 11 asserts neither.
- R6: Pin n's 4-bit function select sits in the register at address 6 for pins 0-7, or address 7 for pins 8-15, at bits 4*(n mod 8)+3:4*(n mod 8). It appears on pad_af[4n+3:4n].
- R7: A write to set/clear with bit n (0-15) set makes latch bit n 1, and bit n+16 set makes it 0. Latch bits whose two controls are both 0 keep their value.
- R8: When bits n and n+16 are both 1 in one set/clear write, latch bit n becomes 1.
- R9: The set/clear register reads back 0. The output latch reads and writes directly at address 3.
- R10: The input register (address 4) returns pad_in in bits 15:0 two clock edges after pad_in changes. Writes to it have no effect.
- R11: Mode, type, pull and function registers read back what was written. Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_od | output | 16 | Open-drain type per pin |
| pad_pu | output | 16 | Pull-up request |
| pad_pd | output | 16 | Pull-down request |
| pad_alt_en | output | 16 | Pin is in alternate-function mode |
| pad_af | output | 64 | 4-bit function select per pin |

## Verification
A register write takes effect at the clock edge that samples bus_we. The pad controls are combinational from the registers, so they change right after that edge, and the bench checks them half a cycle later. Read data is combinational on bus_addr, so the bench sets the address on a falling edge and samples it shortly afterwards. The input register lags pad_in by two rising edges: the bench checks that the old value is still there after one edge and the new value after the second, and in the random runs it waits at least two edges before reading.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      MODE_IN  = 2'b00,
      MODE_OUT = 2'b01,
      MODE_ALT = 2'b10,
      MODE_RSV = 2'b11
   } pin_mode_e;

   localparam logic [1:0] PULL_UP   = 2'b01;
   localparam logic [1:0] PULL_DOWN = 2'b10;

   localparam int REG_MODE   = 0;
   localparam int REG_OTYPE  = 1;
   localparam int REG_PULL   = 2;
   localparam int REG_LATCH  = 3;
   localparam int REG_INPUT  = 4;
   localparam int REG_SETCLR = 5;
   localparam int REG_AF_LO  = 6;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int AF_W     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     we,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_PINS-1:0]      in_sync,
   output logic [DATA_W-1:0]        rdata,
   output logic [2*NUM_PINS-1:0]    mode_q,
   output logic [2*NUM_PINS-1:0]    pull_q,
   output logic [NUM_PINS-1:0]      otype_q,
   output logic [NUM_PINS-1:0]      latch_q,
   output logic [AF_W*NUM_PINS-1:0] af_q
);
   localparam int HALF    = DATA_W / 2;
   localparam int APR     = DATA_W / AF_W;
   localparam int AF_REGS = (NUM_PINS + APR - 1) / APR;

   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
   localparam logic [ADDR_W-1:0] A_OTYPE  = ADDR_W'(REG_OTYPE);
   localparam logic [ADDR_W-1:0] A_PULL   = ADDR_W'(REG_PULL);
   localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(REG_LATCH);
   localparam logic [ADDR_W-1:0] A_INPUT  = ADDR_W'(REG_INPUT);
   localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(REG_SETCLR);

   logic [NUM_PINS-1:0] set_v, clr_v;
   assign set_v = wdata[NUM_PINS-1:0];
   assign clr_v = wdata[HALF +: NUM_PINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         pull_q  <= '0;
         otype_q <= '0;
         latch_q <= '0;
      end else if (we) begin
         if (addr == A_MODE)   mode_q  <= wdata[2*NUM_PINS-1:0];
         if (addr == A_PULL)   pull_q  <= wdata[2*NUM_PINS-1:0];
         if (addr == A_OTYPE)  otype_q <= wdata[NUM_PINS-1:0];
         if (addr == A_LATCH)  latch_q <= wdata[NUM_PINS-1:0];
         if (addr == A_SETCLR) latch_q <= (latch_q & ~clr_v) | set_v;
      end
   end

   logic [DATA_W-1:0] af_word [AF_REGS];

   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_af
         localparam logic [ADDR_W-1:0] A_AF = ADDR_W'(REG_AF_LO + n / APR);
         localparam int OFS = AF_W * (n % APR);
         logic [AF_W-1:0] af_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  af_r <= '0;
            else if (we && addr == A_AF) af_r <= wdata[OFS +: AF_W];
         end
         assign af_q[AF_W*n +: AF_W] = af_r;
      end
      for (genvar k = 0; k < AF_REGS; k++) begin : g_afw
         always_comb begin
            af_word[k] = '0;
            for (int j = 0; j < APR; j++) begin
               if (k * APR + j < NUM_PINS)
                  af_word[k][AF_W*j +: AF_W] = af_q[AF_W*(k*APR+j) +: AF_W];
            end
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == A_MODE)       rdata[2*NUM_PINS-1:0] = mode_q;
      else if (addr == A_OTYPE) rdata[NUM_PINS-1:0]   = otype_q;
      else if (addr == A_PULL)  rdata[2*NUM_PINS-1:0] = pull_q;
      else if (addr == A_LATCH) rdata[NUM_PINS-1:0]   = latch_q;
      else if (addr == A_INPUT) rdata[NUM_PINS-1:0]   = in_sync;
      else begin
         for (int k = 0; k < AF_REGS; k++) begin
            if (addr == ADDR_W'(REG_AF_LO + k)) rdata = af_word[k];
         end
      end
   end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input  logic [2*NUM_PINS-1:0] mode_q,
   input  logic [2*NUM_PINS-1:0] pull_q,
   input  logic [NUM_PINS-1:0]   otype_q,
   input  logic [NUM_PINS-1:0]   latch_q,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_pu,
   output logic [NUM_PINS-1:0]   pad_pd,
   output logic [NUM_PINS-1:0]   pad_alt_en
);
   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
         pin_mode_e md;
         assign md = pin_mode_e'(mode_q[2*n +: 2]);
         always_comb begin
            pad_out[n]    = 1'b0;
            pad_oe[n]     = 1'b0;
            pad_alt_en[n] = 1'b0;
            case (md)
               MODE_OUT: begin
                  if (otype_q[n]) begin
                     pad_out[n] = 1'b0;
                     pad_oe[n]  = ~latch_q[n];
                  end else begin
                     pad_out[n] = latch_q[n];
                     pad_oe[n]  = 1'b1;
                  end
               end
               MODE_ALT: pad_alt_en[n] = 1'b1;
               default:  ;
            endcase
         end
         assign pad_pu[n] = (pull_q[2*n +: 2] == PULL_UP);
         assign pad_pd[n] = (pull_q[2*n +: 2] == PULL_DOWN);
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int NUM_PINS    = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int AF_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_we,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_PINS-1:0]      pad_in,
   output logic [NUM_PINS-1:0]      pad_out,
   output logic [NUM_PINS-1:0]      pad_oe,
   output logic [NUM_PINS-1:0]      pad_od,
   output logic [NUM_PINS-1:0]      pad_pu,
   output logic [NUM_PINS-1:0]      pad_pd,
   output logic [NUM_PINS-1:0]      pad_alt_en,
   output logic [AF_W*NUM_PINS-1:0] pad_af
);
   generate
      if (2 * NUM_PINS > DATA_W) begin : g_bad_width
         $error("two-bit fields and set/clear halves need 2*NUM_PINS <= DATA_W");
      end
      if (NUM_PINS > 2 * (DATA_W / AF_W)) begin : g_bad_af
         $error("function select must fit in two registers");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchroniser needs at least two stages");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("register map needs at least 3 address bits");
      end
   endgenerate

   logic [2*NUM_PINS-1:0] mode_q, pull_q;
   logic [NUM_PINS-1:0]   otype_q, latch_q, in_sync;

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(in_sync)
   );

   gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AF_W(AF_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .in_sync(in_sync), .rdata(bus_rdata), .mode_q(mode_q), .pull_q(pull_q),
      .otype_q(otype_q), .latch_q(latch_q), .af_q(pad_af)
   );

   gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
      .mode_q(mode_q), .pull_q(pull_q), .otype_q(otype_q), .latch_q(latch_q),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .pad_alt_en(pad_alt_en)
   );

   assign pad_od = otype_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int NUM_PINS    = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_od,
   input logic [NUM_PINS-1:0] pad_pu,
   input logic [NUM_PINS-1:0] pad_pd,
   input logic [NUM_PINS-1:0] pad_alt_en,
   input logic [NUM_PINS-1:0] latch_q
);
   localparam int HALF = DATA_W / 2;
   localparam logic [ADDR_W-1:0] A_INPUT  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(5);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0);

   p_alt_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_alt_en & (pad_oe | pad_out)) == '0);

   p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & pad_out) == '0);

   p_setclr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_SETCLR) |-> (bus_rdata == '0));

   p_setclr_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && $past(bus_we) && $past(bus_addr) == A_SETCLR) |->
      (latch_q == (($past(latch_q) & ~$past(bus_wdata[HALF +: NUM_PINS]))
                   | $past(bus_wdata[NUM_PINS-1:0]))));

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         p_input_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && bus_addr == A_INPUT) |->
            (bus_rdata[NUM_PINS-1:0] == $past(pad_in, 2)));
      end
   endgenerate
endmodule

bind gpio_port_ctrl gpio_port_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
   .pad_pd(pad_pd), .pad_alt_en(pad_alt_en), .latch_q(latch_q)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_alt_en;
   logic [63:0] pad_af;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_mode, m_pull, m_afl, m_afh;
   logic [15:0] m_otype, m_latch;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
      .pad_pd(pad_pd), .pad_alt_en(pad_alt_en), .pad_af(pad_af)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = '0; m_pull = '0; m_afl = '0; m_afh = '0; m_otype = '0; m_latch = '0;
   endtask

   task automatic model_write(input logic [3:0] a, input logic [31:0] d);
      case (a)
         4'd0: m_mode  = d;
         4'd1: m_otype = d[15:0];
         4'd2: m_pull  = d;
         4'd3: m_latch = d[15:0];
         4'd5: m_latch = (m_latch & ~d[31:16]) | d[15:0];
         4'd6: m_afl   = d;
         4'd7: m_afh   = d;
         default: ;
      endcase
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0: return m_mode;
         4'd1: return {16'h0, m_otype};
         4'd2: return m_pull;
         4'd3: return {16'h0, m_latch};
         4'd4: return {16'h0, pad_in};
         4'd6: return m_afl;
         4'd7: return m_afh;
         default: return 32'h0;
      endcase
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_check(input string req, input logic [3:0] a);
      bus_addr = a;
      #1;
      check(req, {32'h0, bus_rdata}, {32'h0, exp_read(a)});
   endtask

   task automatic pads_check(input string tag);
      logic [15:0] e_out, e_oe, e_alt, e_pu, e_pd;
      for (int n = 0; n < 16; n++) begin
         logic [1:0] md;
         md = m_mode[2*n +: 2];
         e_out[n] = (md == 2'b01) && !m_otype[n] && m_latch[n];
         e_oe[n]  = (md == 2'b01) && (m_otype[n] ? !m_latch[n] : 1'b1);
         e_alt[n] = (md == 2'b10);
         e_pu[n]  = (m_pull[2*n +: 2] == 2'b01);
         e_pd[n]  = (m_pull[2*n +: 2] == 2'b10);
      end
      check({tag, " R2/R4 pad_out"}, {48'h0, pad_out}, {48'h0, e_out});
      check({tag, " R2/R3/R4 pad_oe"}, {48'h0, pad_oe}, {48'h0, e_oe});
      check({tag, " R3 pad_alt_en"}, {48'h0, pad_alt_en}, {48'h0, e_alt});
      check({tag, " R4 pad_od"}, {48'h0, pad_od}, {48'h0, m_otype});
      check({tag, " R5 pad_pu"}, {48'h0, pad_pu}, {48'h0, e_pu});
      check({tag, " R5 pad_pd"}, {48'h0, pad_pd}, {48'h0, e_pd});
      check({tag, " R6 pad_af"}, pad_af, {m_afh, m_afl});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      pads_check("R1 reset");
      for (int a = 0; a < 16; a++) rd_check("R1 reset readback", 4'(a));

      // R2 push-pull output, R7 set/clear
      wr(4'd0, 32'h5555_5555);
      wr(4'd5, 32'h0000_00F0);
      rd_check("R7 set bits", 4'd3);
      pads_check("R2 pushpull");
      wr(4'd5, 32'h0030_0000);
      rd_check("R7 clear bits", 4'd3);
      wr(4'd5, 32'h0000_0000);
      rd_check("R7 zero write keeps latch", 4'd3);
      // R8 set wins
      wr(4'd3, 32'h0000_0000);
      wr(4'd5, 32'h0001_0001);
      rd_check("R8 set priority", 4'd3);
      check("R8 latch value", {48'h0, m_latch}, 64'h1);
      // R9 set/clear reads zero; latch direct
      rd_check("R9 setclr read zero", 4'd5);
      wr(4'd3, 32'hFFFF_A5C3);
      rd_check("R9 latch direct", 4'd3);
      // R3 modes 11 and 10; R4 open drain
      wr(4'd0, 32'hE4E4_E4E4);
      wr(4'd1, 32'h00FF);
      pads_check("R3/R4 mixed");
      // R10 input latency and write ignored
      @(negedge clk);
      pad_in = 16'h1234;
      repeat (3) @(negedge clk);
      wr(4'd4, 32'hFFFF_FFFF);
      rd_check("R10 input write ignored", 4'd4);
      pad_in = 16'hBEEF;
      @(negedge clk);
      bus_addr = 4'd4; #1;
      check("R10 one edge still old", {48'h0, bus_rdata[15:0]}, 64'h1234);
      @(negedge clk);
      #1;
      check("R10 two edges new", {48'h0, bus_rdata[15:0]}, 64'hBEEF);
      // R11 unmapped
      wr(4'd9, 32'hFFFF_FFFF);
      rd_check("R11 unmapped read", 4'd9);
      for (int a = 0; a < 8; a++) rd_check("R11 unmapped write no effect", 4'(a));

      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         pad_in = 16'($urandom);
         a = 4'($urandom_range(0, 9));
         wr(a, $urandom);
         @(negedge clk);
         pads_check("rand");
         rd_check("R11 rand readback", 4'($urandom_range(0, 15)));
         rd_check("R10 rand input", 4'd4);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule